// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes for a multiplexed external memory bus in the style of a classic 8-bit controller. It runs on the oscillator clock and divides every machine cycle of twelve oscillator periods into two halves of six. For each machine cycle a sequencer presents one cycle kind: idle (internal only), code fetch, data read or data write. It also presents three qualifiers: whether the data address is 16 bits wide, whether the part is running code from external memory, and a control bit that gates the address latch strobe.

From these inputs the block drives five signals. The first is the active-high address latch strobe. The next three are active-low strobes for program-store read, data read and data write. The last two are steering selects for the shared pins: one tells the low-byte port whether to carry the address or the data byte, and the other tells the high-byte port whether to carry the upper address byte or its own output latch. The sequencer and the pad drivers are outside this block. The inputs are sampled once per machine cycle, on the clock edge that ends its last period, and they control the whole of the next machine cycle.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale_o` and both selects are 0, and `psen_n_o`, `rd_n_o` and `wr_n_o` are 1.
- R2: A machine cycle lasts 12 clock periods, numbered 0 to 11. Period 0 is the first rising edge after reset is released. The inputs are sampled only at the edge that enters period 0, and changes at any other time have no effect on that cycle.
- R3: Take a cycle that is not a data cycle and in which gating does not apply. In it `ale_o` is high in periods 0, 1, 6 and 7 and low in all others, so it pulses at one sixth of the clock rate.
- R4: In a data read (`cyc_kind_i`=2) or data write (3) cycle, `ale_o` is high only in periods 0 and 1. The pulse in periods 6 and 7 is skipped.
- R5: With `ale_gate_i`=1 and `ext_mode_i`=0, `ale_o` stays low for the whole of an idle cycle (`cyc_kind_i`=0). It keeps its normal pattern in fetch (1), read and write cycles.
- R6: With `ext_mode_i`=1, `ale_gate_i` has no effect on `ale_o`.
- R7: `psen_n_o` is low in periods 3, 4, 5, 9, 10 and 11 of a fetch cycle, and of an idle cycle when `ext_mode_i`=1. It is high in all other cycles, so both of its pulses are skipped in data cycles.
- R8: `rd_n_o` is low in periods 6 to 11 of a read cycle, and `wr_n_o` is low in periods 6 to 11 of a write cycle. Both are high at all other times, and they are never low together.
- R9: `p0_addr_o` is 1 (address phase) exactly while `ale_o` is high in a cycle that uses the bus, meaning a fetch, read or write cycle, or any cycle with `ext_mode_i`=1. In every other period it is 0 (data phase).
- R10: `p2_high_o` holds one value for the whole machine cycle. It is 1 in fetch cycles, in data cycles with `wide_addr_i`=1, and in idle cycles with `ext_mode_i`=1. It is 0 otherwise, which includes 8-bit-address data cycles, where the port carries its own latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_kind_i | input | 2 | Next cycle kind: 0 idle, 1 fetch, 2 data read, 3 data write |
| wide_addr_i | input | 1 | Data access uses a 16-bit address |
| ext_mode_i | input | 1 | Code is executing from external memory |
| ale_gate_i | input | 1 | Restricts the address latch strobe to bus cycles |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program store read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| p0_addr_o | output | 1 | Low-byte port select: 1 address, 0 data |
| p2_high_o | output | 1 | High-byte port select: 1 upper address, 0 port latch |

## Verification
The hardest states to reach are the overlaps between qualifiers. One is an idle cycle with the gate set while the part runs externally, where the gate must lose. Another is a data cycle in external mode, where program-store pulses must drop and the high-byte select follows the address width rather than the mode. The stimulus first walks all 32 combinations of kind and the three qualifiers in a directed pass. It then runs a seeded random sequence. In that sequence the inputs are also scrambled in the middle of some machine cycles, to show that they are sampled only at the cycle boundary.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_FETCH  = 2'd1,
    CYC_DREAD  = 2'd2,
    CYC_DWRITE = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      wide_addr;
    logic      ext_mode;
    logic      ale_gate;
  } cyc_ctx_t;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic p0_addr;
    logic p2_high;
  } strobe_t;

  localparam cyc_ctx_t CTX_IDLE = '{kind: CYC_IDLE, wide_addr: 1'b0,
                                    ext_mode: 1'b0, ale_gate: 1'b0};

  localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                      wr_n: 1'b1, p0_addr: 1'b0, p2_high: 1'b0};

  // True when pos lies in [start, start+width)
  function automatic logic in_window(input int pos, input int start, input int width);
    return (pos >= start) && (pos < start + width);
  endfunction

  function automatic logic is_data(input cyc_kind_e k);
    return (k == CYC_DREAD) || (k == CYC_DWRITE);
  endfunction

  // A cycle drives the shared bus when it accesses memory or runs externally
  function automatic logic uses_bus(input cyc_ctx_t c);
    return (c.kind != CYC_IDLE) || c.ext_mode;
  endfunction

  // Gate bit only suppresses the strobe in internal-only cycles of internal execution
  function automatic logic ale_permitted(input cyc_ctx_t c);
    return !c.ale_gate || c.ext_mode || (c.kind != CYC_IDLE);
  endfunction

  function automatic logic psen_active(input cyc_ctx_t c);
    return (c.kind == CYC_FETCH) || ((c.kind == CYC_IDLE) && c.ext_mode);
  endfunction

  function automatic logic high_addr_on_p2(input cyc_ctx_t c);
    if (c.kind == CYC_FETCH) return 1'b1;
    if (is_data(c.kind))     return c.wide_addr;
    return c.ext_mode;
  endfunction

endpackage

// File: rtl/mc_phase_ctr.sv
module mc_phase_ctr #(
  parameter int MC_LEN = 12,
  parameter int PW     = $clog2(MC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nxt,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST = PW'(MC_LEN - 1);

  assign last_o    = (phase_q == LAST);
  assign phase_nxt = last_o ? '0 : phase_q + 1'b1;

  // Reset parks on the final period so the first edge opens period 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= LAST;
    else        phase_q <= phase_nxt;
  end
endmodule

// File: rtl/cycle_ctx_latch.sv
module cycle_ctx_latch
  import bus_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_i,
  input  cyc_ctx_t ctx_i,
  output cyc_ctx_t ctx_q,
  output cyc_ctx_t ctx_nxt
);
  assign ctx_nxt = take_i ? ctx_i : ctx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx_q <= CTX_IDLE;
    else        ctx_q <= ctx_nxt;
  end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int MC_HALF = 6,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3,
  parameter int PW      = $clog2(2 * MC_HALF)
) (
  input  logic [PW-1:0] phase_i,
  input  cyc_ctx_t      ctx_i,
  output strobe_t       strobe_o,
  output logic          ale_slot_o,
  output logic          second_half_o
);
  logic [1:0] ale_slot;
  logic [1:0] ale_keep;
  logic [1:0] psen_slot;
  logic       ale_win;
  logic       psen_win;
  logic       data_cyc;

  assign data_cyc = is_data(ctx_i.kind);

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int BASE = h * MC_HALF;
      assign ale_slot[h]  = in_window(int'(phase_i), BASE, ALE_W);
      assign psen_slot[h] = in_window(int'(phase_i), BASE + MC_HALF - PSEN_W, PSEN_W);
      if (h == 0) begin : g_keep_first
        assign ale_keep[h] = 1'b1;
      end else begin : g_skip_data
        assign ale_keep[h] = !data_cyc;
      end
    end
  endgenerate

  assign ale_win       = |(ale_slot & ale_keep);
  assign psen_win      = |psen_slot;
  assign second_half_o = (int'(phase_i) >= MC_HALF);
  assign ale_slot_o    = ale_win;

  always_comb begin
    strobe_o         = STROBE_IDLE;
    strobe_o.ale     = ale_win && ale_permitted(ctx_i);
    strobe_o.psen_n  = !(psen_win && psen_active(ctx_i));
    strobe_o.rd_n    = !(second_half_o && (ctx_i.kind == CYC_DREAD));
    strobe_o.wr_n    = !(second_half_o && (ctx_i.kind == CYC_DWRITE));
    strobe_o.p0_addr = ale_win && uses_bus(ctx_i);
    strobe_o.p2_high = high_addr_on_p2(ctx_i);
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int MC_HALF = 6,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cyc_kind_i,
  input  logic       wide_addr_i,
  input  logic       ext_mode_i,
  input  logic       ale_gate_i,
  output logic       ale_o,
  output logic       psen_n_o,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       p0_addr_o,
  output logic       p2_high_o
);
  localparam int MC_LEN = 2 * MC_HALF;
  localparam int PW     = $clog2(MC_LEN);

  generate
    if (ALE_W + PSEN_W > MC_HALF) begin : g_bad_split
      $error("address strobe and program strobe overlap within a half cycle");
    end
  endgenerate

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          cycle_last;
  cyc_ctx_t      ctx_in;
  cyc_ctx_t      ctx_q;
  cyc_ctx_t      ctx_nxt;
  strobe_t       strobe_nxt;
  strobe_t       strobe_q;
  logic          ale_slot_nxt;
  logic          half2_nxt;
  logic [1:0]    cur_kind;

  assign ctx_in = '{kind: cyc_kind_e'(cyc_kind_i), wide_addr: wide_addr_i,
                    ext_mode: ext_mode_i, ale_gate: ale_gate_i};

  mc_phase_ctr #(.MC_LEN(MC_LEN), .PW(PW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .last_o    (cycle_last)
  );

  cycle_ctx_latch u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (cycle_last),
    .ctx_i   (ctx_in),
    .ctx_q   (ctx_q),
    .ctx_nxt (ctx_nxt)
  );

  // Decode the coming period so every strobe leaves a flop
  strobe_decode #(.MC_HALF(MC_HALF), .ALE_W(ALE_W), .PSEN_W(PSEN_W), .PW(PW)) u_dec (
    .phase_i       (phase_nxt),
    .ctx_i         (ctx_nxt),
    .strobe_o      (strobe_nxt),
    .ale_slot_o    (ale_slot_nxt),
    .second_half_o (half2_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= STROBE_IDLE;
    else        strobe_q <= strobe_nxt;
  end

  assign cur_kind  = ctx_q.kind;
  assign ale_o     = strobe_q.ale;
  assign psen_n_o  = strobe_q.psen_n;
  assign rd_n_o    = strobe_q.rd_n;
  assign wr_n_o    = strobe_q.wr_n;
  assign p0_addr_o = strobe_q.p0_addr;
  assign p2_high_o = strobe_q.p2_high;
endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk #(
  parameter int MC_HALF = 6,
  parameter int PW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] phase,
  input logic [1:0]    kind,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          p0_addr,
  input logic          p2_high
);
  localparam int MC_LEN = 2 * MC_HALF;

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(MC_LEN - 1)) |=> (phase == '0));

  assert_ale_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> ((phase == '0) || (phase == PW'(MC_HALF))));

  assert_ale_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind[1] == 1'b1) && (int'(phase) >= MC_HALF)) |-> !ale);

  assert_psen_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));

  assert_rdwr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_rd_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> (phase == PW'(MC_HALF)));

  assert_p0_in_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p0_addr |-> ale);

  assert_p2_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> $stable(p2_high));
endmodule

bind bus_strobe_gen bus_strobe_chk #(.MC_HALF(MC_HALF), .PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase   (phase_q),
  .kind    (cur_kind),
  .ale     (ale_o),
  .psen_n  (psen_n_o),
  .rd_n    (rd_n_o),
  .wr_n    (wr_n_o),
  .p0_addr (p0_addr_o),
  .p2_high (p2_high_o)
);

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_kind_i = 2'd0;
  logic       wide_addr_i = 1'b0;
  logic       ext_mode_i = 1'b0;
  logic       ale_gate_i = 1'b0;
  logic       ale_o, psen_n_o, rd_n_o, wr_n_o, p0_addr_o, p2_high_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk (clk), .rst_n (rst_n), .cyc_kind_i (cyc_kind_i),
    .wide_addr_i (wide_addr_i), .ext_mode_i (ext_mode_i), .ale_gate_i (ale_gate_i),
    .ale_o (ale_o), .psen_n_o (psen_n_o), .rd_n_o (rd_n_o), .wr_n_o (wr_n_o),
    .p0_addr_o (p0_addr_o), .p2_high_o (p2_high_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected values restated as period tables
  function automatic logic e_ale(int p, int k, bit ext, bit gate);
    bit pulse_slot = (p == 0 || p == 1 || p == 6 || p == 7);
    if (k >= 2 && p >= 6) return 1'b0;
    if (gate && !ext && k == 0) return 1'b0;
    return pulse_slot;
  endfunction

  function automatic logic e_psen_n(int p, int k, bit ext);
    bit low_slot = (p >= 3 && p <= 5) || (p >= 9);
    bit on = (k == 1) || (k == 0 && ext);
    return !(low_slot && on);
  endfunction

  function automatic logic e_p0(int p, int k, bit ext);
    bit slot = (p < 2) || ((p == 6 || p == 7) && k < 2);
    return slot && (k != 0 || ext);
  endfunction

  function automatic logic e_p2(int k, bit wide, bit ext);
    case (k)
      1: return 1'b1;
      2, 3: return wide;
      default: return ext;
    endcase
  endfunction

  // Runs one machine cycle: inputs set before the edge that opens period 0
  task automatic run_cycle(input int k, input bit wide, input bit ext, input bit gate,
                           input bit scramble);
    string ale_tag;
    cyc_kind_i = 2'(k); wide_addr_i = wide; ext_mode_i = ext; ale_gate_i = gate;
    if (k >= 2)             ale_tag = "R4";
    else if (gate && ext)   ale_tag = "R6";
    else if (gate)          ale_tag = "R5";
    else                    ale_tag = "R3";
    if (scramble) ale_tag = {ale_tag, "/R2"};
    for (int p = 0; p < 12; p++) begin
      @(posedge clk);
      @(negedge clk);
      check(ale_tag, $sformatf("ale p%0d k%0d", p, k), ale_o, e_ale(p, k, ext, gate));
      check(scramble ? "R7/R2" : "R7", $sformatf("psen_n p%0d k%0d", p, k),
            psen_n_o, e_psen_n(p, k, ext));
      check("R8", $sformatf("rd_n p%0d", p), rd_n_o, !(k == 2 && p >= 6));
      check("R8", $sformatf("wr_n p%0d", p), wr_n_o, !(k == 3 && p >= 6));
      check("R9", $sformatf("p0 p%0d k%0d", p, k), p0_addr_o, e_p0(p, k, ext));
      check("R10", $sformatf("p2 p%0d k%0d", p, k), p2_high_o, e_p2(k, wide, ext));
      if (scramble && p > 0 && p < 11) begin
        cyc_kind_i = 2'($urandom_range(3)); wide_addr_i = 1'($urandom);
        ext_mode_i = 1'($urandom); ale_gate_i = 1'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: outputs during reset, with busy-looking inputs applied
    cyc_kind_i = 2'd3; wide_addr_i = 1'b1; ext_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ale reset", ale_o, 1'b0);
    check("R1", "psen_n reset", psen_n_o, 1'b1);
    check("R1", "rd_n reset", rd_n_o, 1'b1);
    check("R1", "wr_n reset", wr_n_o, 1'b1);
    check("R1", "p0 reset", p0_addr_o, 1'b0);
    check("R1", "p2 reset", p2_high_o, 1'b0);
    rst_n = 1'b1;
    // Directed sweep over every kind and qualifier
    for (int c = 0; c < 32; c++)
      run_cycle(c & 3, c[2], c[3], c[4], 1'b0);
    // Gate versus external mode on idle cycles back to back
    run_cycle(0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cycle(2, 1'b0, 1'b1, 1'b1, 1'b0);
    // Seeded random mix, some cycles with mid-cycle input churn
    for (int n = 0; n < 300; n++)
      run_cycle(int'($urandom_range(3)), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom_range(3) == 0));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule